// File: doc/BRIEF.md
# Key-Guarded Flash Program/Erase Control Registers

This block is the software-facing register set of an on-chip flash controller. A processor reaches it over a plain 32-bit register bus, with an address, a write strobe with data, and a read strobe. The returned data is registered. The control register holds the program, page-erase and mass-erase selects, a start bit and a lock bit. After reset the control and address registers are locked. They open only when two fixed key words are written to the key register, back to back and in the correct order. Any other key traffic shuts the block until the next reset.

Launching an erase starts an internal cycle counter. The counter holds the busy flag for a parameterised number of clocks and then raises the end-of-operation flag. With the program select set, each half-word write on the flash data port is screened against two conditions: the current cell content must be the erased value, and the region must not be write-protected. A half-word that passes is forwarded to the external array as a one-cycle strobe and keeps the block busy for the program duration. A half-word that fails raises an error flag instead.

Top module: `flash_keyctl`

## Requirements
- R1: After reset the control register (offset 0x10) reads 0x80 (lock bit 7 set, all other bits 0). The status register (0x0C), the address register (0x14) and the key register (0x04) all read 0.
- R2: Writing 0x45670123 and then 0xCDEF89AB to the key register (0x04), with no other key write between them, clears the lock bit, so the control register reads 0x00.
- R3: Any key write that breaks that sequence leaves the block locked until reset. This covers a wrong first word, a wrong second word, and the two words in reversed order. The block stays locked even if a correct sequence follows.
- R4: While the lock bit is 1, writes to the control register and the address register have no effect.
- R5: Writing the control register with bit 7 = 1 while unlocked sets the lock bit again. A fresh correct key sequence then unlocks the block again.
- R6: Writing the control register with bit 6 (start) = 1 and bit 1 (page erase) = 1 makes status bit 0 (busy) read 1 for exactly ERASE_CYC consecutive cycles. Start reads 1 while busy and returns to 0 in the same cycle that busy falls.
- R7: Writing the control register with start and bit 2 (mass erase) set keeps busy high for exactly MASS_CYC cycles.
- R8: Status bit 5 (end of operation) becomes 1 in the same cycle that busy falls. Writing 1 to bit 5 clears it.
- R9: With control bit 0 (program) set, a half-word write on the flash port to a cell reading 0xFFFF in an unprotected region produces one cycle of arr_we, one cycle later, carrying that address and data. Busy is then high for exactly PROG_CYC cycles.
- R10: A program write to a cell not reading 0xFFFF sets status bit 2 instead. It gives no strobe and no busy. Writing 1 to bit 2 clears the bit.
- R11: A program write to a write-protected region (cell_wprot = 1) sets status bit 4. It gives no strobe and no busy. Writing 1 to bit 4 clears the bit.
- R12: While busy is 1, writes to the control and address registers and flash-port writes have no effect.
- R13: With control bit 0 clear, flash-port writes give no strobe and leave the status register at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Byte offset into the register window |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_re | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_re |
| fl_we | input | 1 | Half-word write to the flash address space |
| fl_addr | input | ADDR_W | Flash half-word address |
| fl_wdata | input | 16 | Flash half-word data |
| cell_rdata | input | 16 | Current array content at fl_addr |
| cell_wprot | input | 1 | fl_addr lies in a write-protected region |
| arr_we | output | 1 | One-cycle program strobe to the array |
| arr_addr | output | ADDR_W | Address for the program strobe |
| arr_wdata | output | 16 | Data for the program strobe |

## Verification
A register read returns the state as it stood just before the clock edge that captured reg_re. The bench therefore samples reg_rdata at the falling edge after that capture edge. Busy is high from the edge that accepts a start or program write for exactly the operation length. To measure this, the bench keeps a status read asserted every cycle from the cycle after the write and counts the busy samples. The first idle sample must also show end of operation. The array strobe appears one edge after the flash write, and the bench reads it at the next falling edge. A total strobe count shows that a rejected write produced no strobe.

// File: rtl/flkc_pkg.sv
package flkc_pkg;
    localparam logic [31:0] KEY_FIRST  = 32'h4567_0123;
    localparam logic [31:0] KEY_SECOND = 32'hCDEF_89AB;

    // word index = byte offset / 4
    localparam logic [3:0] IDX_KEY  = 4'd1;
    localparam logic [3:0] IDX_STAT = 4'd3;
    localparam logic [3:0] IDX_CTRL = 4'd4;
    localparam logic [3:0] IDX_ADDR = 4'd5;

    localparam int CR_PG    = 0;
    localparam int CR_PER   = 1;
    localparam int CR_MER   = 2;
    localparam int CR_START = 6;
    localparam int CR_LOCK  = 7;

    localparam int SR_BSY   = 0;
    localparam int SR_PGERR = 2;
    localparam int SR_WPERR = 4;
    localparam int SR_EOP   = 5;

    localparam logic [15:0] ERASED_HW = 16'hFFFF;

    typedef enum logic [1:0] {KG_WAIT1, KG_WAIT2, KG_OPEN, KG_DEAD} kg_state_t;
    typedef enum logic [1:0] {OP_NONE, OP_PAGE, OP_MASS, OP_PROG} op_kind_t;

    typedef struct packed {
        logic pg;
        logic per;
        logic mer;
        logic start;
    } ctrl_t;

    function automatic logic [3:0] word_index(input logic [5:0] byte_off);
        return byte_off[5:2];
    endfunction
endpackage

// File: rtl/flkc_keyguard.sv
module flkc_keyguard
    import flkc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        key_we,
    input  logic [31:0] key_data,
    input  logic        relock,
    output logic        unlocked,
    output logic        dead
);
    kg_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= KG_WAIT1;
        end else begin
            case (st_q)
                KG_WAIT1: if (key_we) st_q <= (key_data == KEY_FIRST)  ? KG_WAIT2 : KG_DEAD;
                KG_WAIT2: if (key_we) st_q <= (key_data == KEY_SECOND) ? KG_OPEN  : KG_DEAD;
                KG_OPEN:  if (relock) st_q <= KG_WAIT1;
                default:  st_q <= KG_DEAD;
            endcase
        end
    end

    assign unlocked = (st_q == KG_OPEN);
    assign dead     = (st_q == KG_DEAD);
endmodule

// File: rtl/flkc_optimer.sv
module flkc_optimer
    import flkc_pkg::*;
#(
    parameter int ERASE_CYC = 20,
    parameter int MASS_CYC  = 40,
    parameter int PROG_CYC  = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     launch,
    input  op_kind_t kind,
    output logic     busy,
    output logic     done
);
    localparam int MAX_A = (ERASE_CYC > MASS_CYC) ? ERASE_CYC : MASS_CYC;
    localparam int MAXC  = (MAX_A > PROG_CYC) ? MAX_A : PROG_CYC;
    localparam int CW    = $clog2(MAXC + 1);

    logic          running_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [CW-1:0] span(input op_kind_t k);
        case (k)
            OP_PAGE: return CW'(ERASE_CYC - 1);
            OP_MASS: return CW'(MASS_CYC - 1);
            default: return CW'(PROG_CYC - 1);
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
        end else if (!running_q) begin
            if (launch) begin
                running_q <= 1'b1;
                cnt_q     <= span(kind);
            end
        end else if (cnt_q == '0) begin
            running_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = running_q;
    assign done = running_q && (cnt_q == '0);
endmodule

// File: rtl/flash_keyctl.sv
module flash_keyctl
    import flkc_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int ERASE_CYC = 20,
    parameter int MASS_CYC  = 40,
    parameter int PROG_CYC  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [5:0]        reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_re,
    output logic [31:0]       reg_rdata,
    input  logic              fl_we,
    input  logic [ADDR_W-1:0] fl_addr,
    input  logic [15:0]       fl_wdata,
    input  logic [15:0]       cell_rdata,
    input  logic              cell_wprot,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [15:0]       arr_wdata
);
    logic [3:0]        widx;
    logic              unlocked, dead, lock;
    logic              bsy, op_done;
    logic              cr_wr, sr_wr, ar_wr, key_wr;
    logic              start_req, prog_try, prog_go, relock;
    op_kind_t          op_kind;
    ctrl_t             cr_q;
    logic              start_q;
    logic              eop_q, pgerr_q, wperr_q;
    logic [ADDR_W-1:0] ar_q;
    logic [31:0]       rd_mux;

    assign widx   = word_index(reg_addr);
    assign lock   = !unlocked;
    assign key_wr = reg_we && (widx == IDX_KEY);
    assign sr_wr  = reg_we && (widx == IDX_STAT);
    assign cr_wr  = reg_we && (widx == IDX_CTRL) && unlocked && !bsy;
    assign ar_wr  = reg_we && (widx == IDX_ADDR) && unlocked && !bsy;
    assign relock = cr_wr && reg_wdata[CR_LOCK];

    assign start_req = cr_wr && reg_wdata[CR_START] && (reg_wdata[CR_PER] ^ reg_wdata[CR_MER]);
    assign prog_try  = fl_we && cr_q.pg && unlocked && !bsy && !start_req;
    assign prog_go   = prog_try && !cell_wprot && (cell_rdata == ERASED_HW);

    always_comb begin
        if (prog_go)               op_kind = OP_PROG;
        else if (reg_wdata[CR_PER]) op_kind = OP_PAGE;
        else                        op_kind = OP_MASS;
    end

    flkc_keyguard u_keyguard (
        .clk      (clk),
        .rst      (rst),
        .key_we   (key_wr),
        .key_data (reg_wdata),
        .relock   (relock),
        .unlocked (unlocked),
        .dead     (dead)
    );

    flkc_optimer #(
        .ERASE_CYC (ERASE_CYC),
        .MASS_CYC  (MASS_CYC),
        .PROG_CYC  (PROG_CYC)
    ) u_optimer (
        .clk    (clk),
        .rst    (rst),
        .launch (start_req || prog_go),
        .kind   (op_kind),
        .busy   (bsy),
        .done   (op_done)
    );

    assign start_q = cr_q.start;

    always_ff @(posedge clk) begin
        if (rst) begin
            cr_q      <= '0;
            eop_q     <= 1'b0;
            pgerr_q   <= 1'b0;
            wperr_q   <= 1'b0;
            ar_q      <= '0;
            arr_we    <= 1'b0;
            arr_addr  <= '0;
            arr_wdata <= '0;
            reg_rdata <= '0;
        end else begin
            if (cr_wr) begin
                cr_q.pg    <= reg_wdata[CR_PG];
                cr_q.per   <= reg_wdata[CR_PER];
                cr_q.mer   <= reg_wdata[CR_MER];
                cr_q.start <= start_req;
            end else if (op_done) begin
                cr_q.start <= 1'b0;
            end

            if (op_done)                        eop_q <= 1'b1;
            else if (sr_wr && reg_wdata[SR_EOP]) eop_q <= 1'b0;

            if (prog_try && !cell_wprot && (cell_rdata != ERASED_HW)) pgerr_q <= 1'b1;
            else if (sr_wr && reg_wdata[SR_PGERR])                    pgerr_q <= 1'b0;

            if (prog_try && cell_wprot)              wperr_q <= 1'b1;
            else if (sr_wr && reg_wdata[SR_WPERR])   wperr_q <= 1'b0;

            if (ar_wr) ar_q <= reg_wdata[ADDR_W-1:0];

            arr_we <= prog_go;
            if (prog_go) begin
                arr_addr  <= fl_addr;
                arr_wdata <= fl_wdata;
            end

            if (reg_re) reg_rdata <= rd_mux;
        end
    end

    always_comb begin
        rd_mux = '0;
        case (widx)
            IDX_STAT: begin
                rd_mux[SR_BSY]   = bsy;
                rd_mux[SR_PGERR] = pgerr_q;
                rd_mux[SR_WPERR] = wperr_q;
                rd_mux[SR_EOP]   = eop_q;
            end
            IDX_CTRL: begin
                rd_mux[CR_PG]    = cr_q.pg;
                rd_mux[CR_PER]   = cr_q.per;
                rd_mux[CR_MER]   = cr_q.mer;
                rd_mux[CR_START] = cr_q.start;
                rd_mux[CR_LOCK]  = lock;
            end
            IDX_ADDR: rd_mux[ADDR_W-1:0] = ar_q;
            default:  rd_mux = '0;
        endcase
    end
endmodule

// File: rtl/flkc_checker.sv
module flkc_checker #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              bsy,
    input logic              eop,
    input logic              start,
    input logic              lock,
    input logic              dead,
    input logic [ADDR_W-1:0] ar,
    input logic              arr_we
);
    // R8
    eop_on_fall_chk: assert property (@(posedge clk) disable iff (rst) $fell(bsy) |-> eop);

    // R6
    start_clear_chk: assert property (@(posedge clk) disable iff (rst) $fell(bsy) |-> !start);

    // R3
    dead_sticks_chk: assert property (@(posedge clk) disable iff (rst) dead |=> (dead && lock));

    // R4
    locked_addr_chk: assert property (@(posedge clk) disable iff (rst) lock |=> $stable(ar));

    // R12
    busy_addr_chk: assert property (@(posedge clk) disable iff (rst) bsy |=> $stable(ar));

    // R9
    strobe_busy_chk: assert property (@(posedge clk) disable iff (rst) arr_we |-> bsy);

    // R9
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst) arr_we |=> !arr_we);
endmodule

bind flash_keyctl flkc_checker #(.ADDR_W(ADDR_W)) u_flkc_checker (
    .clk    (clk),
    .rst    (rst),
    .bsy    (bsy),
    .eop    (eop_q),
    .start  (start_q),
    .lock   (lock),
    .dead   (dead),
    .ar     (ar_q),
    .arr_we (arr_we)
);

// File: tb/flash_keyctl_test.sv
module flash_keyctl_test;
    localparam int AW  = 20;
    localparam int EC  = 20;
    localparam int MC  = 40;
    localparam int PC  = 5;
    localparam logic [5:0] A_KEY = 6'h04, A_SR = 6'h0C, A_CR = 6'h10, A_AR = 6'h14;
    localparam logic [31:0] K1 = 32'h4567_0123, K2 = 32'hCDEF_89AB;

    // key sequence table: first word, second word, expected CR readback
    localparam int NKEY = 5;
    localparam logic [31:0] KT_A [NKEY] = '{K1, K2, 32'h1111_0000, K1, K1};
    localparam logic [31:0] KT_B [NKEY] = '{K2, K1, K2, 32'h0000_2222, K1};
    localparam logic [31:0] KT_E [NKEY] = '{32'h00, 32'h80, 32'h80, 32'h80, 32'h80};

    logic clk = 0, rst = 1;
    logic [5:0]    reg_addr = '0;
    logic          reg_we = 0, reg_re = 0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          fl_we = 0;
    logic [AW-1:0] fl_addr = '0;
    logic [15:0]   fl_wdata = '0;
    logic [15:0]   cell_rdata = 16'hFFFF;
    logic          cell_wprot = 0;
    logic          arr_we;
    logic [AW-1:0] arr_addr;
    logic [15:0]   arr_wdata;

    int checks = 0, errors = 0, strobes = 0;

    flash_keyctl #(.ADDR_W(AW), .ERASE_CYC(EC), .MASS_CYC(MC), .PROG_CYC(PC)) uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_re(reg_re), .reg_rdata(reg_rdata), .fl_we(fl_we), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata), .cell_rdata(cell_rdata), .cell_wprot(cell_wprot),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    always #10 clk = ~clk;

    always @(posedge clk) if (!rst && arr_we) strobes <= strobes + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1;
        @(negedge clk);
        @(negedge clk) rst = 0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk) begin reg_addr = a; reg_wdata = d; reg_we = 1; end
        @(negedge clk) reg_we = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk) begin reg_addr = a; reg_re = 1; end
        @(negedge clk) begin reg_re = 0; d = reg_rdata; end
    endtask

    task automatic unlock();
        wr(A_KEY, K1);
        wr(A_KEY, K2);
    endtask

    // called right at the negedge after the launching edge
    task automatic measure(output int n, output logic eop_at_fall);
        logic seen;
        n = 0; seen = 0; eop_at_fall = 0;
        reg_addr = A_SR; reg_re = 1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (reg_rdata[0]) begin n++; seen = 1; end
            else if (seen) begin eop_at_fall = reg_rdata[5]; break; end
        end
        reg_re = 0;
    endtask

    task automatic prog_hw(input logic [AW-1:0] a, input logic [15:0] d,
                           output logic stb, output logic [AW-1:0] sa, output logic [15:0] sd,
                           output int n, output logic eop_f);
        @(negedge clk) begin fl_addr = a; fl_wdata = d; fl_we = 1; end
        @(negedge clk) begin fl_we = 0; stb = arr_we; sa = arr_addr; sd = arr_wdata; end
        n = 0; eop_f = 0;
        reg_addr = A_SR; reg_re = 1;
        @(negedge clk);
        for (int i = 0; i < 50; i++) begin
            if (reg_rdata[0]) n++;
            else if (n > 0) begin eop_f = reg_rdata[5]; break; end
            else if (i > 2) break;
            @(negedge clk);
        end
        reg_re = 0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n;
        logic e, stb;
        logic [AW-1:0] sa;
        logic [15:0] sd;
        int s0;

        // key sequence table walk (R2 / R3)
        for (int i = 0; i < NKEY; i++) begin
            do_reset();
            wr(A_KEY, KT_A[i]);
            wr(A_KEY, KT_B[i]);
            rd(A_CR, v);
            check((i == 0) ? "R2 key unlock" : "R3 bad key sequence", v, KT_E[i]);
            if (i != 0) begin
                unlock();
                rd(A_CR, v);
                check("R3 correct sequence after bad one stays locked", v, 32'h80);
            end
        end

        // reset state
        do_reset();
        rd(A_CR, v);  check("R1 CR reset", v, 32'h80);
        rd(A_SR, v);  check("R1 SR reset", v, 32'h0);
        rd(A_AR, v);  check("R1 AR reset", v, 32'h0);
        rd(A_KEY, v); check("R1 KEY reads zero", v, 32'h0);

        // locked writes ignored
        wr(A_CR, 32'h0000_0042);
        wr(A_AR, 32'h0000_0555);
        rd(A_CR, v); check("R4 CR write while locked", v, 32'h80);
        rd(A_AR, v); check("R4 AR write while locked", v, 32'h0);
        rd(A_SR, v); check("R4 no operation while locked", v, 32'h0);

        // relock and reopen
        unlock();
        wr(A_CR, 32'h0000_0080);
        rd(A_CR, v); check("R5 relock", v, 32'h80);
        unlock();
        rd(A_CR, v); check("R5 reopen after relock", v, 32'h00);

        // page erase duration and EOP
        wr(A_AR, 32'h0000_0400);
        rd(A_AR, v); check("R6 AR write while unlocked", v, 32'h400);
        wr(A_CR, 32'h0000_0042);
        measure(n, e);
        check("R6 page erase busy cycles", n, EC);
        check("R8 EOP when busy falls", {31'b0, e}, 32'h1);
        rd(A_CR, v); check("R6 start cleared after erase", v, 32'h02);
        wr(A_SR, 32'h0000_0020);
        rd(A_SR, v); check("R8 EOP write-one clear", v, 32'h0);

        // start visible and writes ignored while busy
        wr(A_CR, 32'h0000_0042);
        wr(A_AR, 32'h0000_0777);
        wr(A_CR, 32'h0000_0001);
        rd(A_CR, v); check("R6 start reads 1 while busy", v, 32'h42);
        repeat (EC + 4) @(negedge clk);
        rd(A_AR, v); check("R12 AR write during busy ignored", v, 32'h400);
        rd(A_CR, v); check("R12 CR write during busy ignored", v, 32'h02);
        wr(A_SR, 32'h0000_0020);

        // mass erase
        wr(A_CR, 32'h0000_0044);
        measure(n, e);
        check("R7 mass erase busy cycles", n, MC);
        check("R8 EOP after mass erase", {31'b0, e}, 32'h1);
        wr(A_SR, 32'h0000_0020);

        // PG clear: flash write ignored
        wr(A_CR, 32'h0000_0000);
        s0 = strobes;
        prog_hw(20'h00010, 16'hA5A5, stb, sa, sd, n, e);
        check("R13 no strobe without PG", strobes - s0, 0);
        rd(A_SR, v); check("R13 status untouched without PG", v, 32'h0);

        // good program
        wr(A_CR, 32'h0000_0001);
        cell_rdata = 16'hFFFF; cell_wprot = 0;
        s0 = strobes;
        prog_hw(20'h00123, 16'h3C5A, stb, sa, sd, n, e);
        check("R9 strobe one cycle after write", {31'b0, stb}, 32'h1);
        check("R9 strobe address", {12'b0, sa}, 32'h123);
        check("R9 strobe data", {16'b0, sd}, 32'h3C5A);
        check("R9 single strobe", strobes - s0, 1);
        check("R9 program busy cycles", n, PC);
        check("R8 EOP after program", {31'b0, e}, 32'h1);
        wr(A_SR, 32'h0000_0020);

        // flash write during busy (erase running) ignored
        wr(A_CR, 32'h0000_0042);
        s0 = strobes;
        @(negedge clk) begin fl_addr = 20'h00200; fl_wdata = 16'h1111; fl_we = 1; end
        @(negedge clk) fl_we = 0;
        repeat (EC + 4) @(negedge clk);
        check("R12 flash write during busy ignored", strobes - s0, 0);
        wr(A_SR, 32'h0000_0020);
        wr(A_CR, 32'h0000_0001);

        // non-erased cell
        cell_rdata = 16'h1234;
        s0 = strobes;
        prog_hw(20'h00300, 16'h0F0F, stb, sa, sd, n, e);
        check("R10 no strobe on non-erased", strobes - s0, 0);
        check("R10 no busy on non-erased", n, 0);
        rd(A_SR, v); check("R10 program error flag", v, 32'h04);
        wr(A_SR, 32'h0000_0004);
        rd(A_SR, v); check("R10 program error clear", v, 32'h0);

        // protected region
        cell_rdata = 16'hFFFF; cell_wprot = 1;
        s0 = strobes;
        prog_hw(20'h00400, 16'h0F0F, stb, sa, sd, n, e);
        check("R11 no strobe on protected", strobes - s0, 0);
        check("R11 no busy on protected", n, 0);
        rd(A_SR, v); check("R11 protect error flag", v, 32'h10);
        wr(A_SR, 32'h0000_0010);
        rd(A_SR, v); check("R11 protect error clear", v, 32'h0);
        cell_wprot = 0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule